// File: doc/BRIEF.md
# Hierarchical carry-lookahead adder

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns the sum and the carry-out. It has no clock and no register stage.

Inside, a single 4-way lookahead unit is used again at every level of a radix-4 tree. At the bottom, bit cells form a generate term and a propagate term for each operand bit. Each lookahead unit takes four generate/propagate pairs and a carry-in. It returns the carries into its four children, together with a group generate/propagate pair that it passes to the unit above.

Carries move down the tree. Every group takes its carry-in from its parent unit, so carries never ripple from one group to the next. The carry that a lower unit forms out of its own fourth position is discarded. The overall carry-out is the fourth carry of the root unit.

Top module: `cla_adder`

## Requirements
- R1: For each operand bit, the generate term is `a & b` and the propagate term is the inclusive OR `a | b`. Generate therefore always implies propagate.
- R2: Each sum bit is `a ^ b ^ c`, where `c` is the carry into that bit. When both operand bits are 1, the sum bit equals the incoming carry.
- R3: Inside a lookahead unit, the carry into child 0 is the unit's carry-in. The carry into child j+1 equals `g[j] | p[j] & c[j]`. All four carries are expanded straight from the carry-in.
- R4: A unit's group propagate is the AND of its four propagates. Its group generate is `g3 | p3 g2 | p3 p2 g1 | p3 p2 p1 g0`. Its fourth carry equals `G | P & carry_in`.
- R5: Every lower group takes its carry-in from its parent unit, and a lower unit's own fourth carry is not used. At every bit boundary, including the 4-bit and 16-bit boundaries, the carry into bit i+1 equals `g[i] | p[i] & c[i]`.
- R6: `cout_o` is the fourth carry of the root unit. It equals the root's `G | P & cin_i`.
- R7: For any operands, `{cout_o, sum_o}` equals `a_i + b_i + cin_i`.
- R8: `WIDTH` must be 4, 16 or 64. The tree has log4(`WIDTH`) levels of lookahead units, and any other width is rejected at elaboration.
- R9: An all-ones operand plus zero with carry-in 1 gives a sum of zero and a carry-out of 1. The carry travels through the full width.
- R10: Zero plus zero gives sum 0 and carry-out 0 when carry-in is 0. It gives sum 1 and carry-out 0 when carry-in is 1.
- R11: The alternating patterns `...1010` plus `...0101` give all ones with carry-out 0. With carry-in 1 they give zero with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Two of the block's functions can act on the same bit at once: a local carry generate, and propagation of an incoming carry. Because propagate is an OR, this happens whenever both operand bits are 1. Equal all-ones operands and the alternating patterns, each with both carry-in values, drive this case hard. So do random vectors in which one operand is the complement of the other, which builds carry chains across the 4-bit and 16-bit group boundaries. Every result is compared with a bench-computed `a + b + cin`, at the 64-, 16- and 4-bit widths side by side.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // generate/propagate pair carried through every level of the tree
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    localparam int unsigned RADIX = 4;

    // R8: legal widths form a full radix-4 tree
    function automatic bit width_ok(input int unsigned width);
        return (width == 4) || (width == 16) || (width == 64);
    endfunction

    function automatic int unsigned tree_levels(input int unsigned width);
        int unsigned n;
        int unsigned span;
        n = 0;
        span = 1;
        while (span < width) begin
            span = span * RADIX;
            n++;
        end
        return n;
    endfunction

    // number of nodes on level lvl (level 0 = single bits)
    function automatic int unsigned level_size(input int unsigned width, input int unsigned lvl);
        return width >> (2 * lvl);
    endfunction

    // flat index of the first node on level lvl
    function automatic int unsigned level_base(input int unsigned width, input int unsigned lvl);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < lvl; j++) begin
            acc = acc + level_size(width, j);
        end
        return acc;
    endfunction

    // one carry step in ripple form, used only as a cross-check
    function automatic logic carry_step(input pg_t pg, input logic cin);
        return pg.gen | (pg.prop & cin);
    endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
    import cla_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output pg_t  pg_o,
    output logic s_o
);

    always_comb begin
        pg_o.gen  = a_i & b_i;
        pg_o.prop = a_i | b_i;
        s_o       = a_i ^ b_i ^ c_i;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i})) begin
            AST_GEN_IMPLIES_PROP: assert (!pg_o.gen || pg_o.prop) else $error("generate without propagate"); // R1
            AST_SUM_WHEN_BOTH: assert (!(a_i && b_i) || (s_o == c_i)) else $error("sum wrong with both bits set"); // R2
        end
    end

endmodule

// File: rtl/cla_leaf_row.sv
module cla_leaf_row
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output pg_t  [WIDTH-1:0] pg_o,
    output logic [WIDTH-1:0] s_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        cla_bit_cell u_cell (
            .a_i  (a_i[i]),
            .b_i  (b_i[i]),
            .c_i  (c_i[i]),
            .pg_o (pg_o[i]),
            .s_o  (s_o[i])
        );
    end

endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4
    import cla_pkg::*;
(
    input  pg_t  [3:0] pg_i,
    input  logic       c_i,
    output logic [4:1] c_o,
    output pg_t        grp_o
);

    logic [3:0] p;
    logic [3:0] g;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            p[k] = pg_i[k].prop;
            g[k] = pg_i[k].gen;
        end
    end

    // every carry expanded directly from c_i, no serial chain
    always_comb begin
        c_o[1] = g[0] | (p[0] & c_i);
        c_o[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_i);
        c_o[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
               | (p[2] & p[1] & p[0] & c_i);
        c_o[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
               | (p[3] & p[2] & p[1] & g[0]) | (&p & c_i);
        grp_o.prop = &p;
        grp_o.gen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0]);
    end

    always_comb begin
        if (!$isunknown({pg_i, c_i})) begin
            AST_CARRY_CHAIN: assert ((c_o[1] == carry_step(pg_i[0], c_i))
                                  && (c_o[2] == carry_step(pg_i[1], c_o[1]))
                                  && (c_o[3] == carry_step(pg_i[2], c_o[2]))) else $error("lookahead carry mismatch"); // R3
            AST_GROUP_CARRY: assert (c_o[4] == carry_step(grp_o, c_i)) else $error("group carry mismatch"); // R4
            AST_FULL_PROP: assert (!(grp_o.prop && c_i) || (&c_o)) else $error("carry lost through full propagate"); // R4
        end
    end

endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned LEVELS = tree_levels(WIDTH);
    localparam int unsigned TOP    = level_base(WIDTH, LEVELS);
    localparam int unsigned NODES  = TOP + 1;

    if (!width_ok(WIDTH)) begin : g_bad_width
        $error("cla_adder: WIDTH must be 4, 16 or 64"); // R8
    end

    // node_pg: generate/propagate of every tree node, level by level
    // node_c : carry into every tree node
    pg_t  [NODES-1:0] node_pg;
    logic [NODES-1:0] node_c;

    cla_leaf_row #(.WIDTH(WIDTH)) u_leaf (
        .a_i  (a_i),
        .b_i  (b_i),
        .c_i  (node_c[WIDTH-1:0]),
        .pg_o (node_pg[WIDTH-1:0]),
        .s_o  (sum_o)
    );

    assign node_c[TOP] = cin_i;

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
        localparam int unsigned BASE  = level_base(WIDTH, lvl);
        localparam int unsigned UP    = level_base(WIDTH, lvl + 1);
        localparam int unsigned UNITS = level_size(WIDTH, lvl + 1);

        for (genvar u = 0; u < UNITS; u++) begin : g_unit
            logic [4:1] cy;

            cla_lookahead4 u_la (
                .pg_i  (node_pg[BASE + 4*u +: 4]),
                .c_i   (node_c[UP + u]),
                .c_o   (cy),
                .grp_o (node_pg[UP + u])
            );

            // carries fed back down to the four children
            assign node_c[BASE + 4*u]      = node_c[UP + u];
            assign node_c[BASE + 4*u + 1]  = cy[1];
            assign node_c[BASE + 4*u + 2]  = cy[2];
            assign node_c[BASE + 4*u + 3]  = cy[3];

            if (lvl == LEVELS - 1) begin : g_root
                assign cout_o = cy[4];
            end else if ((u % 4) != 3) begin : g_sibling
                // local fourth carry is dropped; it must agree with the parent's
                always_comb begin
                    if (!$isunknown({a_i, b_i, cin_i})) begin
                        AST_SIBLING_CARRY: assert (cy[4] == node_c[UP + u + 1]) else $error("group carry disagrees with parent"); // R5
                    end
                end
            end else begin : g_last
                always_comb begin
                    if (!$isunknown({a_i, b_i, cin_i})) begin
                        AST_LAST_CARRY: assert (cy[4] == carry_step(node_pg[UP + u], node_c[UP + u])) else $error("last group carry mismatch"); // R5
                    end
                end
            end
        end
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            for (int i = 0; i < int'(WIDTH) - 1; i++) begin
                AST_BOUNDARY_RIPPLE: assert (node_c[i+1] == carry_step(node_pg[i], node_c[i])) else $error("bit carry mismatch at %0d", i); // R5
            end
            AST_COUT_GROUP: assert (cout_o == carry_step(node_pg[TOP], cin_i)) else $error("carry-out mismatch"); // R6
            AST_SUM_EXACT: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})) else $error("sum mismatch"); // R7
        end
    end

endmodule

// File: tb/cla_adder_tb.sv
`timescale 1ns/1ps
module cla_adder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [63:0] a_r = '0;
    logic [63:0] b_r = '0;
    logic        cin_r = 1'b0;

    logic [63:0] sum64;
    logic [15:0] sum16;
    logic [3:0]  sum4;
    logic        cout64, cout16, cout4;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cla_adder #(.WIDTH(64)) u_dut (
        .a_i(a_r), .b_i(b_r), .cin_i(cin_r), .sum_o(sum64), .cout_o(cout64));
    cla_adder #(.WIDTH(16)) u_dut16 (
        .a_i(a_r[15:0]), .b_i(b_r[15:0]), .cin_i(cin_r), .sum_o(sum16), .cout_o(cout16));
    cla_adder #(.WIDTH(4)) u_dut4 (
        .a_i(a_r[3:0]), .b_i(b_r[3:0]), .cin_i(cin_r), .sum_o(sum4), .cout_o(cout4));

    // reference: carry lands at bit w
    function automatic logic [64:0] ref_add(input logic [63:0] a, input logic [63:0] b,
                                            input logic c, input int w);
        logic [63:0] m;
        m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        return {1'b0, a & m} + {1'b0, b & m} + {64'd0, c};
    endfunction

    task automatic judge(input string req, input int w, input logic [64:0] got,
                         input logic [64:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s width %0d: got %h expected %h (a=%h b=%h cin=%b)",
                     req, w, got, exp, a_r, b_r, cin_r);
        end
    endtask

    task automatic check_vec(input logic [63:0] a, input logic [63:0] b,
                             input logic c, input string req);
        logic [64:0] e;
        @(negedge clk);
        a_r = a;
        b_r = b;
        cin_r = c;
        #1;
        e = ref_add(a, b, c, 64);
        judge(req, 64, {cout64, sum64}, e);
        e = ref_add(a, b, c, 16);
        judge(req, 16, {48'd0, cout16, sum16}, {48'd0, e[16:0]});
        e = ref_add(a, b, c, 4);
        judge(req, 4, {60'd0, cout4, sum4}, {60'd0, e[4:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero operands give zero result (R10)
        #1;
        n_run++;
        if ({cout64, sum64} !== 65'd0) begin
            n_fail++;
            $display("FAIL R10 reset state: got %h expected 0", {cout64, sum64});
        end
        @(posedge clk);
        rst = 1'b0;

        check_vec(64'd0, 64'd0, 1'b0, "R10 zero cin0");
        check_vec(64'd0, 64'd0, 1'b1, "R10 zero cin1");
        check_vec({64{1'b1}}, 64'd0, 1'b1, "R9 ones plus cin");
        check_vec(64'd0, {64{1'b1}}, 1'b1, "R9 ones in b plus cin");
        check_vec({32{2'b10}}, {32{2'b01}}, 1'b0, "R11 alternating cin0");
        check_vec({32{2'b10}}, {32{2'b01}}, 1'b1, "R11 alternating cin1");
        check_vec({64{1'b1}}, {64{1'b1}}, 1'b0, "R2 both bits set cin0");
        check_vec({64{1'b1}}, {64{1'b1}}, 1'b1, "R2 both bits set cin1");
        check_vec({32{2'b10}}, {32{2'b10}}, 1'b1, "R1 R2 equal alternating");
        check_vec(64'h7, 64'h0, 1'b1, "R3 carry inside first group");
        check_vec(64'h3, 64'h1, 1'b0, "R3 generate inside group");
        check_vec(64'hF, 64'h1, 1'b0, "R5 carry across 4-bit boundary");
        check_vec(64'hFFFF, 64'h0, 1'b1, "R4 carry across 16-bit group");
        check_vec(64'h0000_FFFF_FFFF_FFF0, 64'h10, 1'b0, "R4 R5 long chain into top group");
        check_vec(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R6 carry-out from top bit");
        check_vec(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R6 no carry-out");
        check_vec(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, "R8 all three widths");

        for (int i = 0; i < 1500; i++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            check_vec(ra, rb, 1'($urandom()), "R7 random");
        end
        for (int i = 0; i < 800; i++) begin
            ra = {$urandom(), $urandom()};
            rb = ~ra ^ (64'd1 << ($urandom() % 64));
            check_vec(ra, rb, 1'($urandom()), "R5 propagate chain");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule